// File: doc/BRIEF.md
# Triggered Exposure and Strobe Sequencer

This block turns an asynchronous trigger, already isolated from the outside world, into a timed exposure window and a flash strobe pulse. It brings the trigger into the logic clock domain and reacts only to a low-to-high transition. After a programmable trigger delay, the sequence reaches its *delayed trigger point*. From that point the exposure waits for the sensor's next row-readout start pulse and then for a fixed, programmable offset. The shutter-control output is then held high for a programmed number of cycles.

The strobe output has its own delay and width timer. This timer runs in parallel with the exposure path. Both strobe times are counted from the delayed trigger point. Because the exposure start is locked to row timing, the image integration always begins at the same position relative to the row readout. The strobe stays tied to the trigger, not to the row.

All configuration values are sampled when the trigger edge is accepted. A `busy` flag covers the whole sequence, and trigger edges that arrive while it is high are dropped.

Top module: `expo_trigger_seq`

## Requirements
- R1: Only a low-to-high transition of `trig_raw` starts a sequence. A level that stays high, or that rises while `busy` is high, starts nothing once the current sequence ends.
- R2: The raw trigger goes through a SYNC_STAGES-flop synchronizer (default 2). If `trig_raw` is first sampled high at clock edge k, the edge is accepted at edge k+SYNC_STAGES (the capture edge E0), and `busy` is high from that edge.
- R3: The delayed trigger point Td lies `cfg_trig_delay` cycles after E0. A delay of 0 makes Td equal to E0.
- R4: Exposure is armed only by a `row_start` pulse sampled at an edge R strictly after Td. Pulses at Td or earlier, and pulses after the first qualifying one, have no effect. `shutter_on` rises at edge R + `cfg_row_offset`.
- R5: `shutter_on` stays high for exactly `cfg_expo_len` cycles. A length of 0 produces no shutter pulse.
- R6: `strobe_on` rises at edge Td + `cfg_strobe_delay` and stays high for exactly `cfg_strobe_len` cycles, whatever the exposure is doing. A length of 0 produces no strobe pulse.
- R7: `busy` is high from E0 until both paths have finished. It falls at edge max(R + offset + exposure length, Td + strobe delay + strobe length).
- R8: All configuration inputs are captured at E0. Changing them later in the sequence does not alter the current timing.
- R9: A synchronous active-high `rst` returns the block to idle, with `shutter_on`, `strobe_on` and `busy` low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_raw | input | 1 | Isolated trigger, asynchronous to clk |
| row_start | input | 1 | One-cycle marker at the start of a row readout |
| cfg_trig_delay | input | DLY_W | Cycles from the accepted edge to the delayed trigger point |
| cfg_row_offset | input | DLY_W | Cycles from the qualifying row pulse to exposure start |
| cfg_expo_len | input | DUR_W | Exposure length in cycles; 0 suppresses the exposure |
| cfg_strobe_delay | input | DLY_W | Cycles from the delayed trigger point to strobe start |
| cfg_strobe_len | input | DUR_W | Strobe width in cycles; 0 suppresses the strobe |
| shutter_on | output | 1 | Internal shutter control, high during exposure |
| strobe_on | output | 1 | Strobe output |
| busy | output | 1 | High while a sequence is in progress |

## Verification
The assertions assume three things about the inputs:
- `row_start` is a single-cycle marker.
- The configuration inputs may change at any time.
- Reset is applied at startup, before any trigger activity.

They also take the synchronizer output as the only source of sequence starts.

The stimulus follows these assumptions:
- Every row marker is a one-cycle pulse.
- Extra markers are placed on edges the block must ignore.
- Configuration is rewritten right after the capture edge.
- The trigger is held low during every reset, so that no edge is detected when the reset is released.

// File: rtl/expo_seq_pkg.sv
package expo_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TDLY,
      ST_WROW,
      ST_OFFS,
      ST_EXPO
   } seq_state_e;

endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("trig_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         prev  <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~prev;

   // R1: one transition gives a single-cycle event
   assert_edge_single_R1: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);

endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] len,
   output logic         active,
   output logic         last
);

   generate
      if (W < 1) begin : g_bad_width
         $error("seq_timer: W must be at least 1");
      end
   endgenerate

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= len;
      end else if (cnt != '0) begin
         cnt <= cnt - ONE;
      end
   end

   assign active = (cnt != '0);
   assign last   = (cnt == ONE);

   // R5: a running window shrinks by exactly one each cycle
   assert_count_down_R5: assert property (@(posedge clk) disable iff (rst)
      (!load && active) |=> (cnt == $past(cnt) - ONE));

   // R8: a load takes the value presented with it
   assert_load_value_R8: assert property (@(posedge clk) disable iff (rst)
      load |=> (cnt == $past(len)));

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen #(
   parameter int DLY_W = 16,
   parameter int DUR_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fire,
   input  logic [DLY_W-1:0] sdel,
   input  logic [DUR_W-1:0] slen,
   output logic             strobe,
   output logic             pending
);

   logic             dly_active, dly_last;
   logic             len_active, len_last;
   logic             dly_load, len_load;
   logic [DUR_W-1:0] len_q, len_val;

   always_ff @(posedge clk) begin
      if (rst)       len_q <= '0;
      else if (fire) len_q <= slen;
   end

   assign dly_load = fire && (sdel != '0);
   assign len_load = (fire && (sdel == '0)) || (dly_last && !fire);
   assign len_val  = fire ? slen : len_q;

   seq_timer #(.W(DLY_W)) u_dly (
      .clk(clk), .rst(rst), .load(dly_load), .len(sdel),
      .active(dly_active), .last(dly_last));

   seq_timer #(.W(DUR_W)) u_len (
      .clk(clk), .rst(rst), .load(len_load), .len(len_val),
      .active(len_active), .last(len_last));

   assign strobe  = len_active;
   assign pending = dly_active | len_active;

   // R6: the strobe starts only from a fire with no delay or at the end of its delay
   assert_strobe_start_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(strobe) |-> ($past(dly_last) || $past(fire && (sdel == '0))));

   // R6: the strobe ends after its last counted cycle
   assert_strobe_end_R6: assert property (@(posedge clk) disable iff (rst)
      (len_last && !len_load) |=> !strobe);

endmodule

// File: rtl/expo_trigger_seq.sv
module expo_trigger_seq
   import expo_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DLY_W       = 16,
   parameter int DUR_W       = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             trig_raw,
   input  logic             row_start,
   input  logic [DLY_W-1:0] cfg_trig_delay,
   input  logic [DLY_W-1:0] cfg_row_offset,
   input  logic [DUR_W-1:0] cfg_expo_len,
   input  logic [DLY_W-1:0] cfg_strobe_delay,
   input  logic [DUR_W-1:0] cfg_strobe_len,
   output logic             shutter_on,
   output logic             strobe_on,
   output logic             busy
);

   generate
      if (DLY_W < 1 || DUR_W < 1) begin : g_bad_widths
         $error("expo_trigger_seq: DLY_W and DUR_W must be at least 1");
      end
   endgenerate

   seq_state_e       state, state_nx;
   logic             trig_rise, accept, dtrig;
   logic             strobe_pend;
   logic             tdly_load, tdly_active, tdly_last;
   logic             off_load, off_active, off_last;
   logic             expo_go, expo_load, expo_active, expo_last;
   logic             row_hit;
   logic [DLY_W-1:0] cap_off, cap_sdel, sdel_now;
   logic [DUR_W-1:0] cap_exp, cap_slen, slen_now;

   trig_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .din(trig_raw), .rise(trig_rise));

   assign busy   = (state != ST_IDLE) || strobe_pend;
   assign accept = trig_rise && !busy;

   // configuration snapshot at the accepted edge
   always_ff @(posedge clk) begin
      if (rst) begin
         cap_off  <= '0;
         cap_sdel <= '0;
         cap_exp  <= '0;
         cap_slen <= '0;
      end else if (accept) begin
         cap_off  <= cfg_row_offset;
         cap_sdel <= cfg_strobe_delay;
         cap_exp  <= cfg_expo_len;
         cap_slen <= cfg_strobe_len;
      end
   end

   assign tdly_load = accept && (cfg_trig_delay != '0);
   assign dtrig     = (accept && (cfg_trig_delay == '0)) ||
                      ((state == ST_TDLY) && tdly_last);
   assign sdel_now  = (state == ST_IDLE) ? cfg_strobe_delay : cap_sdel;
   assign slen_now  = (state == ST_IDLE) ? cfg_strobe_len   : cap_slen;

   assign row_hit   = (state == ST_WROW) && row_start;
   assign off_load  = row_hit && (cap_off != '0);
   assign expo_go   = (row_hit && (cap_off == '0)) ||
                      ((state == ST_OFFS) && off_last);
   assign expo_load = expo_go && (cap_exp != '0);

   seq_timer #(.W(DLY_W)) u_tdly (
      .clk(clk), .rst(rst), .load(tdly_load), .len(cfg_trig_delay),
      .active(tdly_active), .last(tdly_last));

   seq_timer #(.W(DLY_W)) u_off (
      .clk(clk), .rst(rst), .load(off_load), .len(cap_off),
      .active(off_active), .last(off_last));

   seq_timer #(.W(DUR_W)) u_expo (
      .clk(clk), .rst(rst), .load(expo_load), .len(cap_exp),
      .active(expo_active), .last(expo_last));

   strobe_gen #(.DLY_W(DLY_W), .DUR_W(DUR_W)) u_strobe (
      .clk(clk), .rst(rst), .fire(dtrig), .sdel(sdel_now), .slen(slen_now),
      .strobe(strobe_on), .pending(strobe_pend));

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE: begin
            if (accept) state_nx = (cfg_trig_delay == '0) ? ST_WROW : ST_TDLY;
         end
         ST_TDLY: begin
            if (tdly_last) state_nx = ST_WROW;
         end
         ST_WROW: begin
            if (row_hit) begin
               if (cap_off != '0)      state_nx = ST_OFFS;
               else if (cap_exp != '0) state_nx = ST_EXPO;
               else                    state_nx = ST_IDLE;
            end
         end
         ST_OFFS: begin
            if (off_last) state_nx = (cap_exp != '0) ? ST_EXPO : ST_IDLE;
         end
         ST_EXPO: begin
            if (expo_last) state_nx = ST_IDLE;
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_IDLE;
      else     state <= state_nx;
   end

   assign shutter_on = expo_active;

   // R1: a sequence only begins on a detected transition
   assert_start_on_edge_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(trig_rise));

   // R3: the delay phase is backed by a running counter
   assert_delay_running_R3: assert property (@(posedge clk) disable iff (rst)
      (state == ST_TDLY) |-> tdly_active);

   // R4: exposure begins only after a qualifying row pulse or its offset
   assert_shutter_after_row_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(shutter_on) |-> ($past(state) == ST_OFFS ||
                             ($past(state) == ST_WROW && $past(row_start))));

   // R4: the offset phase is backed by a running counter
   assert_offset_running_R4: assert property (@(posedge clk) disable iff (rst)
      (state == ST_OFFS) |-> off_active);

   // R7: both outputs lie inside the busy window
   assert_outputs_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
      (shutter_on || strobe_on) |-> busy);

   // R9: one cycle after reset everything is quiet
   assert_reset_quiet_R9: assert property (@(posedge clk)
      $past(rst) |-> (!shutter_on && !strobe_on && !busy));

endmodule

// File: tb/expo_trigger_seq_test.sv
module expo_trigger_seq_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        trig_raw = 1'b0;
   logic        row_start = 1'b0;
   logic [15:0] cfg_trig_delay = '0, cfg_row_offset = '0, cfg_strobe_delay = '0;
   logic [15:0] cfg_expo_len = '0, cfg_strobe_len = '0;
   logic        shutter_on, strobe_on, busy;

   int cyc = 0;
   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   expo_trigger_seq uut (
      .clk(clk), .rst(rst), .trig_raw(trig_raw), .row_start(row_start),
      .cfg_trig_delay(cfg_trig_delay), .cfg_row_offset(cfg_row_offset),
      .cfg_expo_len(cfg_expo_len), .cfg_strobe_delay(cfg_strobe_delay),
      .cfg_strobe_len(cfg_strobe_len),
      .shutter_on(shutter_on), .strobe_on(strobe_on), .busy(busy));

   task automatic chk(input string req, input string nm, input logic act, input logic expv);
      vectors++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, nm, cyc, act, expv);
      end
   endtask

   // R9: quiet outputs after reset
   task automatic t_reset_state();
      @(negedge clk);
      rst = 1'b1;
      trig_raw = 1'b0;
      @(negedge clk);
      chk("R9", "shutter_on", shutter_on, 1'b0);
      chk("R9", "strobe_on", strobe_on, 1'b0);
      chk("R9", "busy", busy, 1'b0);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9", "busy idle", busy, 1'b0);
   endtask

   // One full sequence, checked cycle by cycle against the requirement formulas.
   task automatic t_seq(input int d, input int off, input int ex, input int sd, input int sl,
                        input int gap, input bit early, input bit late, input bit retrig);
      int n0, k, e0, td, r, exp_end, st_end, fin;
      @(negedge clk);
      cfg_trig_delay   = 16'(d);
      cfg_row_offset   = 16'(off);
      cfg_expo_len     = 16'(ex);
      cfg_strobe_delay = 16'(sd);
      cfg_strobe_len   = 16'(sl);
      n0 = cyc;
      k  = n0 + 1;           // first edge that samples the trigger high
      e0 = k + 2;            // R2: capture edge with two sync stages
      td = e0 + d;           // R3
      r  = td + gap;         // R4: qualifying row edge
      exp_end = r + off + ex;
      st_end  = td + sd + sl;
      fin = (exp_end > st_end) ? exp_end : st_end;
      trig_raw = 1'b1;
      for (int i = 0; i < fin + 6 - n0; i++) begin
         int c;
         @(negedge clk);
         c = cyc;
         chk("R3/R4/R5/R8", "shutter_on", shutter_on,
             (ex > 0) && (c >= r + off) && (c < r + off + ex));
         chk("R6/R8", "strobe_on", strobe_on,
             (sl > 0) && (c >= td + sd) && (c < td + sd + sl));
         if (c < e0)        chk("R2", "busy", busy, 1'b0);
         else if (c < fin)  chk("R7", "busy", busy, 1'b1);
         else               chk("R1", "busy after end", busy, 1'b0);
         row_start = (c + 1 == r) || (early && (c + 1 == td || c + 1 == td - 1)) ||
                     (late && (c + 1 == r + 1));
         trig_raw  = ((c + 1 >= k) && (c + 1 <= k + 3)) || (retrig && (c + 1 >= e0 + 4));
         if (c == e0) begin   // R8: rewrite configuration mid-sequence
            cfg_trig_delay   = 16'd9;
            cfg_row_offset   = 16'd7;
            cfg_expo_len     = 16'd1;
            cfg_strobe_delay = 16'd5;
            cfg_strobe_len   = 16'd13;
         end
      end
      row_start = 1'b0;
      trig_raw  = 1'b0;
   endtask

   // R9: reset in the middle of an exposure
   task automatic t_reset_mid();
      @(negedge clk);
      cfg_trig_delay = 16'd1; cfg_row_offset = 16'd0; cfg_expo_len = 16'd40;
      cfg_strobe_delay = 16'd0; cfg_strobe_len = 16'd40;
      trig_raw = 1'b1;
      repeat (6) @(negedge clk);
      row_start = 1'b1;
      @(negedge clk);
      row_start = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9", "shutter before reset", shutter_on, 1'b1);
      rst = 1'b1;
      trig_raw = 1'b0;
      @(negedge clk);
      chk("R9", "shutter_on", shutter_on, 1'b0);
      chk("R9", "strobe_on", strobe_on, 1'b0);
      chk("R9", "busy", busy, 1'b0);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      chk("R9", "busy stays idle", busy, 1'b0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      t_reset_state();
      // delay, offset, row gating with ignored early and late pulses
      t_seq(3, 2, 5, 1, 4, 3, 1'b1, 1'b1, 1'b0);
      // zero trigger delay, zero offset, zero strobe delay
      t_seq(0, 0, 4, 0, 2, 1, 1'b1, 1'b0, 1'b0);
      // exposure suppressed, strobe delayed
      t_seq(2, 1, 0, 6, 3, 2, 1'b0, 1'b0, 1'b0);
      // strobe suppressed
      t_seq(1, 3, 3, 2, 0, 1, 1'b0, 1'b1, 1'b0);
      // strobe outlasts exposure, retrigger while busy
      t_seq(2, 0, 3, 2, 30, 1, 1'b0, 1'b0, 1'b1);
      // long exposure, retrigger while busy
      t_seq(1, 3, 20, 0, 2, 2, 1'b1, 1'b1, 1'b1);
      // long wait for the row marker
      t_seq(4, 5, 6, 3, 3, 10, 1'b1, 1'b0, 1'b0);
      t_reset_mid();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule